// File: doc/BRIEF.md
# Oversampling Serial ADC Averager

This block runs an external 12-bit serial converter over a four-wire SPI link and turns a burst of back-to-back conversions into one mean value per control-loop period. A one-cycle sync pulse at the start of each loop period clears the running sum and starts a fresh burst. The block then frames one conversion after another, each behind a falling chip select and sixteen serial clocks. It shifts in the data line on every falling serial-clock edge and adds each 12-bit result to a wide accumulator. After the last conversion of the burst it divides the sum by the sample count. The divider is a multiply by a fixed reciprocal followed by a right shift.

The mean comes out with a one-cycle valid strobe and is held until the next burst completes. Because every conversion in the period goes into the result, the value handed to the current regulator does not depend on the instant at which any single sample was taken. A sync that arrives while a burst is still running abandons that burst. No result is produced for it, and the new burst starts with the usual quiet gap.

Top module: `adc_burst_avg`

## Requirements
- R1: After reset and until the first sync pulse, chip select and serial clock are high, valid is low and the mean output is 0.
- R2: A sync pulse takes chip select high on the next clock edge. Chip select then stays high for QUIET_CLKS clocks, after which a frame begins. During a frame chip select is low for 2*FRAME_BITS*HALF_CLKS clocks. The serial clock starts high and toggles every HALF_CLKS clocks, giving FRAME_BITS falling edges. It is high whenever chip select is high.
- R3: Between two frames of one burst, chip select stays high for exactly QUIET_CLKS clocks.
- R4: Each frame is sampled MSB first on the falling serial-clock edges. The conversion result is the last DATA_BITS bits received (bits 11..0 of the 16-bit word). The leading FRAME_BITS-DATA_BITS bits have no effect on the result, whatever their value.
- R5: A burst contains exactly NUM_SAMPLES frames. After the last one, chip select and serial clock stay high until the next sync pulse.
- R6: The valid strobe is high for exactly one clock, one clock after chip select rises at the end of the last frame of a burst. At that point the mean output equals floor(sum of the burst's results / NUM_SAMPLES).
- R7: The mean is exact for every reachable sum, including full scale (all results 4095, mean 4095) and a sum one below a multiple of NUM_SAMPLES (409499 gives 4094).
- R8: A sync pulse during a frame or a quiet gap aborts the running burst. Chip select goes high on the next edge, no valid strobe is issued for the aborted burst, and the new burst follows the timing of R2 and R3.
- R9: Between valid strobes the mean output holds its value.
- R10: The accumulator never overflows. It is wide enough for NUM_SAMPLES full-scale results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | One-cycle pulse at the start of each control-loop period |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter, idle high |
| mean_o | output | DATA_BITS | Mean of the last completed burst |
| valid_o | output | 1 | One-cycle strobe marking a new mean |

## Verification
Two situations are hard to reach from the ports. The first is the exactness of the reciprocal divide near its limits. The bench reaches it with a converter model whose words are chosen per burst, so one burst sums to exactly full scale and another to one below a multiple of the sample count. The leading word bits are set in those bursts and in a pseudo-random burst, which shows they are ignored. The second is an abort. Sync pulses are timed to land inside a frame and inside a quiet gap, and a cycle reference model, keyed on the cycles since the last sync, checks that no strobe escapes and that framing restarts cleanly.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;

  typedef enum logic [1:0] {FR_IDLE, FR_QUIET, FR_FRAME} fr_state_e;

  // Accumulator width needed for n results of db bits each.
  function automatic int unsigned acc_width(int unsigned n, int unsigned db);
    return $clog2(n * ((1 << db) - 1) + 1);
  endfunction

  // Shift paired with the reciprocal: accumulator width plus ceil(log2 n).
  function automatic int unsigned recip_shift(int unsigned n, int unsigned accw);
    return accw + $clog2(n);
  endfunction

  // ceil(2^shift / n): exact floor division for every sum below 2^accw.
  function automatic longint unsigned recip_mult(int unsigned n, int unsigned accw);
    longint unsigned p;
    p = 64'd1 << recip_shift(n, accw);
    return (p + 64'(n) - 64'd1) / 64'(n);
  endfunction

endpackage

// File: rtl/adc_frame_gen.sv
module adc_frame_gen
  import adc_avg_pkg::*;
#(
  parameter int HALF_CLKS  = 4,
  parameter int FRAME_BITS = 16,
  parameter int QUIET_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic more_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic fall_o,
  output logic end_o
);
  localparam int HW   = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int EW   = $clog2(2 * FRAME_BITS);
  localparam int QW   = (QUIET_CLKS > 1) ? $clog2(QUIET_CLKS) : 1;
  localparam int GW   = $clog2(QUIET_CLKS + 1) + 1;
  localparam int LAST = 2 * FRAME_BITS - 1;

  fr_state_e      state_q;
  logic [HW-1:0]  hcnt_q;
  logic [EW-1:0]  ecnt_q;
  logic [QW-1:0]  qcnt_q;
  logic           sclk_q;
  logic           tick;

  assign tick   = (state_q == FR_FRAME) && (hcnt_q == HW'(HALF_CLKS - 1));
  assign fall_o = tick && !ecnt_q[0];
  assign end_o  = tick && (ecnt_q == EW'(LAST));
  assign cs_n_o = (state_q != FR_FRAME);
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      hcnt_q  <= '0;
      ecnt_q  <= '0;
      qcnt_q  <= '0;
      sclk_q  <= 1'b1;
    end else if (sync_i) begin
      state_q <= FR_QUIET;
      hcnt_q  <= '0;
      ecnt_q  <= '0;
      qcnt_q  <= '0;
      sclk_q  <= 1'b1;
    end else begin
      case (state_q)
        FR_QUIET: begin
          if (qcnt_q == QW'(QUIET_CLKS - 1)) begin
            state_q <= FR_FRAME;
            hcnt_q  <= '0;
            ecnt_q  <= '0;
          end else begin
            qcnt_q <= qcnt_q + 1'b1;
          end
        end
        FR_FRAME: begin
          if (tick) begin
            hcnt_q <= '0;
            sclk_q <= ~sclk_q;
            if (end_o) begin
              state_q <= more_i ? FR_QUIET : FR_IDLE;
              qcnt_q  <= '0;
            end else begin
              ecnt_q <= ecnt_q + 1'b1;
            end
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Checker counter: consecutive high cycles of chip select before it falls.
  logic [GW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_cnt_q <= '0;
    else if (!cs_n_o)                    hi_cnt_q <= '0;
    else if (hi_cnt_q != GW'(QUIET_CLKS)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt_q == GW'(QUIET_CLKS))); // R3
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o); // R2

endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_i,
  input  logic                 sdi_i,
  output logic [DATA_BITS-1:0] sample_o
);
  // Only DATA_BITS are kept: the leading bits fall out of the top.
  logic [DATA_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[DATA_BITS-2:0], sdi_i};
  end

  assign sample_o = sh_q;

endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
  parameter int NUM_SAMPLES = 100,
  parameter int DATA_BITS   = 12,
  parameter int ACC_W       = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_i,
  input  logic                 add_i,
  input  logic [DATA_BITS-1:0] sample_i,
  output logic [ACC_W-1:0]     acc_o,
  output logic                 more_o,
  output logic                 done_o
);
  localparam int CW = $clog2(NUM_SAMPLES + 1);

  logic [ACC_W-1:0] acc_q;
  logic [CW-1:0]    cnt_q;
  logic             done_q;
  logic [ACC_W:0]   sum_ext;

  assign sum_ext = {1'b0, acc_q} + (ACC_W + 1)'(sample_i);
  assign more_o  = (cnt_q != CW'(NUM_SAMPLES - 1));
  assign acc_o   = acc_q;
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (sync_i) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (add_i) begin
      acc_q  <= sum_ext[ACC_W-1:0];
      cnt_q  <= cnt_q + 1'b1;
      done_q <= !more_o;
    end else begin
      done_q <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !sync_i) |-> !sum_ext[ACC_W]); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NUM_SAMPLES)); // R5

endmodule

// File: rtl/adc_mean_div.sv
module adc_mean_div
  import adc_avg_pkg::*;
#(
  parameter int NUM_SAMPLES = 100,
  parameter int DATA_BITS   = 12,
  parameter int ACC_W       = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [ACC_W-1:0]     sum_i,
  output logic [DATA_BITS-1:0] mean_o,
  output logic                 valid_o
);
  localparam int              SHIFT = recip_shift(NUM_SAMPLES, ACC_W);
  localparam int              RW    = ACC_W + 1;
  localparam int              PW    = ACC_W + RW;
  localparam longint unsigned RECIP = recip_mult(NUM_SAMPLES, ACC_W);

  logic [PW-1:0]        prod;
  logic [DATA_BITS-1:0] quot;

  assign prod = PW'(sum_i) * PW'(RW'(RECIP));
  assign quot = DATA_BITS'(prod >> SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mean_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) mean_o <= quot;
    end
  end

  AST_MEAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((64'(mean_o) * 64'(NUM_SAMPLES) <= 64'($past(sum_i))) &&
                 (64'($past(sum_i)) < (64'(mean_o) + 64'd1) * 64'(NUM_SAMPLES)))); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R6
  AST_MEAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(mean_o)); // R9

endmodule

// File: rtl/adc_burst_avg.sv
module adc_burst_avg
  import adc_avg_pkg::*;
#(
  parameter int HALF_CLKS   = 4,
  parameter int FRAME_BITS  = 16,
  parameter int DATA_BITS   = 12,
  parameter int QUIET_CLKS  = 6,
  parameter int NUM_SAMPLES = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_i,
  input  logic                 sdi_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic [DATA_BITS-1:0] mean_o,
  output logic                 valid_o
);
  localparam int ACC_W = acc_width(NUM_SAMPLES, DATA_BITS);

  // Internal events, named for the assertions.
  logic                 bit_fall;
  logic                 frame_end;
  logic                 more_frames;
  logic                 burst_done;
  logic [DATA_BITS-1:0] sample;
  logic [ACC_W-1:0]     acc_sum;

  adc_frame_gen #(
    .HALF_CLKS (HALF_CLKS),
    .FRAME_BITS(FRAME_BITS),
    .QUIET_CLKS(QUIET_CLKS)
  ) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .sync_i(sync_i),
    .more_i(more_frames),
    .cs_n_o(cs_n_o),
    .sclk_o(sclk_o),
    .fall_o(bit_fall),
    .end_o (frame_end)
  );

  adc_shift_rx #(
    .DATA_BITS(DATA_BITS)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (bit_fall),
    .sdi_i   (sdi_i),
    .sample_o(sample)
  );

  adc_accum #(
    .NUM_SAMPLES(NUM_SAMPLES),
    .DATA_BITS  (DATA_BITS),
    .ACC_W      (ACC_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .add_i   (frame_end),
    .sample_i(sample),
    .acc_o   (acc_sum),
    .more_o  (more_frames),
    .done_o  (burst_done)
  );

  adc_mean_div #(
    .NUM_SAMPLES(NUM_SAMPLES),
    .DATA_BITS  (DATA_BITS),
    .ACC_W      (ACC_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (burst_done),
    .sum_i  (acc_sum),
    .mean_o (mean_o),
    .valid_o(valid_o)
  );

  AST_SYNC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> cs_n_o); // R8
  AST_IDLE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (cs_n_o && sclk_o)); // R5
  AST_FRAME_END_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !sync_i) |=> (cs_n_o && sclk_o)); // R2

endmodule

// File: tb/tb_adc_burst_avg.sv
module tb_adc_burst_avg;
  localparam int HALF = 4;
  localparam int FB   = 16;
  localparam int DB   = 12;
  localparam int Q    = 6;
  localparam int N    = 100;
  localparam int P    = Q + 2 * FB * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_r = 1'b0;
  logic sdi = 1'b0;
  logic cs_n, sclk, valid;
  logic [DB-1:0] mean;

  always #4 clk = ~clk;

  adc_burst_avg #(
    .HALF_CLKS(HALF), .FRAME_BITS(FB), .DATA_BITS(DB),
    .QUIET_CLKS(Q), .NUM_SAMPLES(N)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_r), .sdi_i(sdi),
    .cs_n_o(cs_n), .sclk_o(sclk), .mean_o(mean), .valid_o(valid)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Stimulus words: mode 0 pseudo-random, 1 full scale, 2 one below a multiple.
  int mode = 0;
  int seed = 0;
  int base = 0;
  int exp_next = 0;
  int exp_mean = 0;
  bit aborting = 1'b0;

  function automatic int word_of(int g);
    if (mode == 1) return 16'hFFFF;
    if (mode == 2) return (g == base) ? 16'hFFFE : 16'hFFFF;
    return (g * 40503 + seed * 977 + 12345) & 16'hFFFF;
  endfunction

  // Converter model: first bit at chip-select fall, next on each rising sclk.
  int fidx = 0;
  int bitk = 0;
  logic [15:0] word = '0;
  always @(negedge cs_n) begin
    word = 16'(word_of(fidx));
    fidx++;
    bitk = 0;
    sdi = word[15];
  end
  always @(posedge sclk) begin
    if (!cs_n) begin
      bitk++;
      if (bitk < 16) sdi = word[15 - bitk];
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  // Cycle reference: position in the burst from cycles since the last sync.
  int t = -1;
  bit pend = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      int ecs, esclk, ev, k, r, u;
      if (pend) t = 0;
      else if (t >= 0) t++;
      pend = sync_r;
      if (t < 0) begin
        ecs = 1; esclk = 1; tag = "R1";
      end else begin
        k = t / P; r = t % P;
        if (k >= N) begin
          ecs = 1; esclk = 1; tag = "R5";
        end else if (r < Q) begin
          ecs = 1; esclk = 1; tag = "R3";
        end else begin
          u = r - Q; ecs = 0; esclk = ((u / HALF) % 2 == 0) ? 1 : 0; tag = "R2";
        end
        if (aborting && t < P) tag = "R8";
      end
      ev = (t >= 0 && t == N * P + 1) ? 1 : 0;
      check(cs_n == ecs[0] && sclk == esclk[0], tag, "cs_n*2+sclk",
            {cs_n, sclk}, ecs * 2 + esclk);
      check(valid == ev[0], (t >= 0 && t <= N * P + 1) ? "R6" : "R1", "valid",
            int'(valid), ev);
      if (ev == 1) begin
        exp_mean = exp_next;
        check(int'(mean) == exp_mean, (mode == 0) ? "R4 R6" : "R7", "mean",
              int'(mean), exp_mean);
      end else begin
        check(int'(mean) == exp_mean, (t < 0) ? "R1" : "R9", "mean held",
              int'(mean), exp_mean);
      end
    end
  end

  task automatic fire_sync(int m, int s, bit ab);
    int sum;
    @(posedge clk); #2;
    mode = m; seed = s; base = fidx; aborting = ab;
    sum = 0;
    for (int kk = 0; kk < N; kk++) sum += word_of(base + kk) & 12'hFFF;
    exp_next = sum / N;
    sync_r = 1'b1;
    @(posedge clk); #2;
    sync_r = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (20) @(posedge clk);                 // R1 idle checks
    fire_sync(0, 1, 1'b0);
    repeat (3000) @(posedge clk);               // lands inside a frame
    fire_sync(0, 2, 1'b1);                      // R8 abort mid-frame
    repeat (N * P + 200) @(posedge clk);        // R4 R6 pseudo burst
    fire_sync(1, 0, 1'b0);
    repeat (N * P + 50) @(posedge clk);         // R7 full scale
    fire_sync(2, 0, 1'b0);
    repeat (N * P + 50) @(posedge clk);         // R7 one below multiple
    fire_sync(0, 3, 1'b0);
    repeat (P + 1) @(posedge clk);              // lands in a quiet gap
    fire_sync(0, 4, 1'b1);                      // R8 abort in quiet gap
    repeat (N * P + 100) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule